// File: doc/BRIEF.md
# Request-Grant Memory Bus Master

This block sits between a client and a simple shared memory bus. The client starts a read with a one-cycle pulse and an address. It starts a write with a one-cycle pulse, an address and a data word. The master then runs a fixed sequence on the bus, with one cycle between each step. It raises a single-cycle bus request and samples the grant one cycle later. It drives a read or write command and then presents the address with its valid flag. In the same cycle it either moves one write beat out or takes one read beat in. A captured read word is held on a client-side output. A completion pulse marks the end of every transaction.

Only one transaction is in flight at a time. A busy output tells the client when the master will not take new work. If the grant is missing in the cycle where it is expected, the master raises the request again in the next cycle. There are no stalls beyond that retry and no bursts. All outputs come from flops, and reset is synchronous and active high.

Top module: `mbm_master`

## Requirements
- R1: When idle, a pulse on `rd_go` or `wr_go` sampled at a clock edge makes `busy` and `bus_request` high in the next cycle. `bus_request` stays high for exactly that one cycle.
- R2: `bus_grant` is sampled only in the cycle after a `bus_request` cycle. If it is low there, `bus_request` is raised again in the following cycle, and this repeats until a grant is seen.
- R3: The command is driven in the cycle after the grant cycle: `cmd_rd` for a read and `cmd_wr` for a write. The two command outputs are never high together, and each is high only in such a cycle.
- R4: `bus_addr_vld` is high, with `bus_addr` equal to the client address, exactly in the cycle after a command cycle, and low in every other cycle.
- R5: For a write, `bus_wdata_vld` is high, with `bus_wdata` equal to the client word, in the cycle after `cmd_wr`, and low in every other cycle.
- R6: For a read, `bus_rdata` is captured into `rd_word` at the edge ending the address cycle if `bus_rdata_vld` is high there. `done` goes high at that same edge. `bus_rdata_vld` in any other cycle leaves `rd_word` unchanged and raises no `done`.
- R7: For a write, `done` is high for one cycle, in the cycle after the write beat.
- R8: `busy` is high from the cycle after acceptance through the address cycle, and falls in the `done` cycle. Go pulses sampled while busy are ignored and start no bus activity.
- R9: If `rd_go` and `wr_go` are high in the same cycle while idle, the read is taken and the write is dropped.
- R10: While `rst` is high at a clock edge, all outputs are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_go | input | 1 | Client read start pulse |
| rd_addr | input | 8 | Client read address |
| wr_go | input | 1 | Client write start pulse |
| wr_addr | input | 8 | Client write address |
| wr_word | input | 64 | Client write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | 64 | Last captured read data |
| bus_request | output | 1 | Single-cycle bus request |
| bus_grant | input | 1 | Grant, expected one cycle after request |
| cmd_rd | output | 1 | Read command |
| cmd_wr | output | 1 | Write command |
| bus_addr | output | 8 | Bus address |
| bus_addr_vld | output | 1 | Address valid |
| bus_rdata | input | 64 | Read data beat |
| bus_rdata_vld | input | 1 | Read data valid |
| bus_wdata | output | 64 | Write data beat |
| bus_wdata_vld | output | 1 | Write data valid |

## Verification
The bench checks the exact cycle of each bus step, which exposes an off-by-one in the sequencer as a command or address valid landing one cycle early or late. It withholds the grant once or twice to show that the request is retried rather than the transaction being lost or a command issued with no grant. It pokes the other go input while busy and raises both go inputs together. A design that wrongly accepted these would emit an extra request or a write command. It also raises read data valid while idle, where a careless capture would corrupt `rd_word` or raise a false `done`.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    parameter int unsigned MBM_AW = 8;
    parameter int unsigned MBM_DW = 64;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_CMD  = 3'd3,
        ST_DATA = 3'd4
    } mbm_state_e;

    typedef struct packed {
        logic              is_wr;
        logic [MBM_AW-1:0] addr;
        logic [MBM_DW-1:0] word;
    } mbm_txn_t;

    // Read has priority when both client pulses coincide.
    function automatic mbm_txn_t pick_txn(
        input logic              rd,
        input logic [MBM_AW-1:0] ra,
        input logic [MBM_AW-1:0] wa,
        input logic [MBM_DW-1:0] wd
    );
        mbm_txn_t t;
        t.is_wr = !rd;
        t.addr  = rd ? ra : wa;
        t.word  = rd ? '0 : wd;
        return t;
    endfunction

endpackage

// File: rtl/mbm_txn_hold.sv
module mbm_txn_hold
    import mbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  mbm_txn_t nxt,
    output mbm_txn_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
    import mbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              gnt,
    input  mbm_txn_t          txn,
    output logic              accept,
    output logic              in_data,
    output logic              busy,
    output logic              req,
    output logic              c_rd,
    output logic              c_wr,
    output logic [MBM_AW-1:0] addr,
    output logic              addr_vld,
    output logic [MBM_DW-1:0] wdata,
    output logic              wdata_vld
);
    mbm_state_e st;

    assign accept  = (st == ST_IDLE) && go;
    assign in_data = (st == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            busy      <= 1'b0;
            req       <= 1'b0;
            c_rd      <= 1'b0;
            c_wr      <= 1'b0;
            addr      <= '0;
            addr_vld  <= 1'b0;
            wdata     <= '0;
            wdata_vld <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        st   <= ST_REQ;
                        busy <= 1'b1;
                        req  <= 1'b1;
                    end
                end
                ST_REQ: begin
                    st  <= ST_WAIT;
                    req <= 1'b0;
                end
                ST_WAIT: begin
                    if (gnt) begin
                        st   <= ST_CMD;
                        c_rd <= !txn.is_wr;
                        c_wr <= txn.is_wr;
                    end else begin
                        st  <= ST_REQ;
                        req <= 1'b1;
                    end
                end
                ST_CMD: begin
                    st        <= ST_DATA;
                    c_rd      <= 1'b0;
                    c_wr      <= 1'b0;
                    addr      <= txn.addr;
                    addr_vld  <= 1'b1;
                    wdata     <= txn.word;
                    wdata_vld <= txn.is_wr;
                end
                ST_DATA: begin
                    st        <= ST_IDLE;
                    addr_vld  <= 1'b0;
                    wdata_vld <= 1'b0;
                    busy      <= 1'b0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbm_rd_capture.sv
module mbm_rd_capture
    import mbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_data,
    input  logic              is_wr,
    input  logic [MBM_DW-1:0] rdata,
    input  logic              rdata_vld,
    output logic [MBM_DW-1:0] word,
    output logic              done
);
    logic take;
    assign take = in_data && !is_wr && rdata_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            done <= 1'b0;
        end else begin
            done <= in_data && (is_wr || rdata_vld);
            if (take) begin
                word <= rdata;
            end
        end
    end
endmodule

// File: rtl/mbm_master.sv
module mbm_master
    import mbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_go,
    input  logic [MBM_AW-1:0] rd_addr,
    input  logic              wr_go,
    input  logic [MBM_AW-1:0] wr_addr,
    input  logic [MBM_DW-1:0] wr_word,
    output logic              busy,
    output logic              done,
    output logic [MBM_DW-1:0] rd_word,
    output logic              bus_request,
    input  logic              bus_grant,
    output logic              cmd_rd,
    output logic              cmd_wr,
    output logic [MBM_AW-1:0] bus_addr,
    output logic              bus_addr_vld,
    input  logic [MBM_DW-1:0] bus_rdata,
    input  logic              bus_rdata_vld,
    output logic [MBM_DW-1:0] bus_wdata,
    output logic              bus_wdata_vld
);
    mbm_txn_t nxt_txn;
    mbm_txn_t cur_txn;
    logic     accept;
    logic     in_data;

    assign nxt_txn = pick_txn(rd_go, rd_addr, wr_addr, wr_word);

    mbm_txn_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .nxt  (nxt_txn),
        .cur  (cur_txn)
    );

    mbm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (rd_go || wr_go),
        .gnt       (bus_grant),
        .txn       (cur_txn),
        .accept    (accept),
        .in_data   (in_data),
        .busy      (busy),
        .req       (bus_request),
        .c_rd      (cmd_rd),
        .c_wr      (cmd_wr),
        .addr      (bus_addr),
        .addr_vld  (bus_addr_vld),
        .wdata     (bus_wdata),
        .wdata_vld (bus_wdata_vld)
    );

    mbm_rd_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .is_wr     (cur_txn.is_wr),
        .rdata     (bus_rdata),
        .rdata_vld (bus_rdata_vld),
        .word      (rd_word),
        .done      (done)
    );
endmodule

// File: rtl/mbm_chk.sv
module mbm_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic bus_request,
    input logic bus_grant,
    input logic cmd_rd,
    input logic cmd_wr,
    input logic bus_addr_vld,
    input logic bus_wdata_vld
);
    a_r1_req_single: assert property (@(posedge clk) disable iff (rst)
        bus_request |=> !bus_request);

    a_r3_cmd_after_grant: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd || cmd_wr) |-> $past(bus_grant));

    a_r3_cmd_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cmd_rd && cmd_wr));

    a_r4_addr_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd || cmd_wr) |=> bus_addr_vld);

    a_r4_addr_only_after_cmd: assert property (@(posedge clk) disable iff (rst)
        !(cmd_rd || cmd_wr) |=> !bus_addr_vld);

    a_r5_wbeat_follows_wr: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> bus_wdata_vld);

    a_r5_wbeat_only_after_wr: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> !bus_wdata_vld);

    a_r8_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        bus_request |-> busy);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind mbm_master mbm_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .bus_request   (bus_request),
    .bus_grant     (bus_grant),
    .cmd_rd        (cmd_rd),
    .cmd_wr        (cmd_wr),
    .bus_addr_vld  (bus_addr_vld),
    .bus_wdata_vld (bus_wdata_vld)
);

// File: tb/tb_mbm_master.sv
`timescale 1ns/1ps
module tb_mbm_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_go = 1'b0, wr_go = 1'b0;
    logic [7:0]  rd_addr = '0, wr_addr = '0;
    logic [63:0] wr_word = '0;
    logic        busy, done, bus_request, cmd_rd, cmd_wr, bus_addr_vld, bus_wdata_vld;
    logic [63:0] rd_word, bus_wdata;
    logic [7:0]  bus_addr;
    logic        bus_grant = 1'b0;
    logic [63:0] bus_rdata = '0;
    logic        bus_rdata_vld = 1'b0;

    always #2.5 clk = ~clk;

    mbm_master dut (.*);

    typedef struct { bit wr; logic [7:0] a; logic [63:0] d; } exp_t;
    exp_t sb[$];
    int n_cmp = 0, n_bad = 0;
    int deny_cnt = 0;
    bit stray = 1'b0;
    bit prev_req = 1'b0, prev_crd = 1'b0;
    logic [7:0]  seen_a;
    logic [63:0] seen_d;
    bit          seen_w = 1'b0;

    function automatic logic [63:0] mem_of(input logic [7:0] a);
        return {8{a}} ^ 64'h5A3C_96E1_0F7B_D248;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Bus responder: grant one cycle after request (R2), one read beat after cmd_rd (R6)
    always @(negedge clk) begin
        if (prev_req && deny_cnt == 0) bus_grant = 1'b1;
        else bus_grant = 1'b0;
        if (prev_req && deny_cnt > 0) deny_cnt--;
        prev_req = bus_request;
        if (prev_crd && bus_addr_vld) begin
            bus_rdata_vld = 1'b1;
            bus_rdata     = mem_of(bus_addr);
        end else if (stray) begin
            bus_rdata_vld = 1'b1;
            bus_rdata     = 64'hDEAD_BEEF_0BAD_F00D;
        end else begin
            bus_rdata_vld = 1'b0;
        end
        prev_crd = cmd_rd;
    end

    // Monitor: pop scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_wdata_vld) begin
                seen_w = 1'b1; seen_a = bus_addr; seen_d = bus_wdata;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.wr) begin
                        chk(seen_w && seen_a == e.a, "R5 write addr", {56'd0, seen_a}, {56'd0, e.a});
                        chk(seen_w && seen_d == e.d, "R5 write data", seen_d, e.d);
                    end else begin
                        chk(rd_word == e.d, "R6 read word", rd_word, e.d);
                    end
                    seen_w = 1'b0;
                end
            end
        end
    end

    // Driver: one transaction with cycle-exact checks
    task automatic xact(input bit wr, input logic [7:0] a, input logic [63:0] d,
                        input int denies, input bit poke, input bit both);
        exp_t e;
        @(negedge clk);
        e.wr = wr && !both; e.a = a; e.d = e.wr ? d : mem_of(a);
        sb.push_back(e);
        deny_cnt = denies;
        if (wr || both) begin wr_go = 1'b1; wr_addr = both ? ~a : a; wr_word = d; end
        if (!wr || both) begin rd_go = 1'b1; rd_addr = a; end
        @(negedge clk);
        rd_go = 1'b0; wr_go = 1'b0;
        chk(bus_request == 1'b1, "R1 request", {63'd0, bus_request}, 64'd1);
        chk(busy == 1'b1, "R8 busy", {63'd0, busy}, 64'd1);
        for (int k = 0; k < denies; k++) begin
            @(negedge clk);
            chk(bus_request == 1'b0, "R2 request gap", {63'd0, bus_request}, 64'd0);
            @(negedge clk);
            chk(bus_request == 1'b1, "R2 retry request", {63'd0, bus_request}, 64'd1);
        end
        @(negedge clk);
        chk(!bus_request && !cmd_rd && !cmd_wr, "R1 single request", {62'd0, cmd_rd, bus_request}, 64'd0);
        if (poke) begin
            if (wr) begin rd_go = 1'b1; rd_addr = 8'hEE; end
            else begin wr_go = 1'b1; wr_addr = 8'hEE; wr_word = '1; end
        end
        @(negedge clk);
        rd_go = 1'b0; wr_go = 1'b0;
        chk(cmd_rd == e.wr ? 1'b0 : 1'b1, "R3 cmd_rd", {63'd0, cmd_rd}, {63'd0, !e.wr});
        chk(cmd_wr == e.wr, "R3 cmd_wr/R9", {63'd0, cmd_wr}, {63'd0, e.wr});
        chk(!bus_addr_vld, "R4 addr early", {63'd0, bus_addr_vld}, 64'd0);
        @(negedge clk);
        chk(bus_addr_vld && bus_addr == a, "R4 addr", {55'd0, bus_addr_vld, bus_addr}, {55'd1, a});
        chk(bus_wdata_vld == e.wr, "R5 wbeat valid", {63'd0, bus_wdata_vld}, {63'd0, e.wr});
        chk(!done, "R6 done early", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk(done == 1'b1, e.wr ? "R7 write done" : "R6 read done", {63'd0, done}, 64'd1);
        chk(!busy && !bus_addr_vld && !bus_wdata_vld, "R8 busy end/R4/R5",
            {61'd0, busy, bus_addr_vld, bus_wdata_vld}, 64'd0);
        @(negedge clk);
        chk(!done && !bus_request, "R8 no extra work", {62'd0, done, bus_request}, 64'd0);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog", 64'd1, 64'd0);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !bus_request && !cmd_rd && !cmd_wr && !bus_addr_vld && !bus_wdata_vld
            && rd_word == 0, "R10 reset outputs", {57'd0, busy, done, bus_request, cmd_rd, cmd_wr,
            bus_addr_vld, bus_wdata_vld}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        xact(1'b0, 8'h00, '0, 0, 1'b0, 1'b0);
        xact(1'b0, 8'hFF, '0, 0, 1'b0, 1'b0);
        xact(1'b1, 8'h3C, 64'h0123_4567_89AB_CDEF, 0, 1'b0, 1'b0);
        xact(1'b1, 8'h81, 64'hFFFF_0000_FFFF_0000, 0, 1'b0, 1'b0);
        // R2 missing grant once and twice
        xact(1'b0, 8'h55, '0, 1, 1'b0, 1'b0);
        xact(1'b1, 8'hAA, 64'hCAFE_F00D_1234_5678, 2, 1'b0, 1'b0);
        // R8 go pulses while busy are ignored
        xact(1'b0, 8'h12, '0, 0, 1'b1, 1'b0);
        xact(1'b1, 8'h34, 64'h1111_2222_3333_4444, 0, 1'b1, 1'b0);
        // R9 simultaneous pulses: read wins
        xact(1'b0, 8'h77, '0, 0, 1'b0, 1'b1);
        // R6 stray read valid while idle leaves rd_word alone
        @(negedge clk); stray = 1'b1;
        @(negedge clk); stray = 1'b0;
        @(negedge clk);
        chk(rd_word == mem_of(8'h77), "R6 stray ignored", rd_word, mem_of(8'h77));
        chk(!done, "R6 stray no done", {63'd0, done}, 64'd0);
        chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 64'd0);
        // R10 reset mid-transaction
        @(negedge clk); rd_go = 1'b1; rd_addr = 8'h09;
        @(negedge clk); rd_go = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_request && rd_word == 0, "R10 reset clears", {62'd0, busy, bus_request}, 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule